// File: doc/BRIEF.md
# Symbol-Matrix Sum-and-Parity Encoder

This block adds redundancy to a 64-bit data word before the word is written into a memory. The word is treated as a logical grid of 4-bit symbols, with two rows of eight symbols each. Row 0 holds bits 31..0 and row 1 holds bits 63..32. The memory cells themselves are not rearranged. Within each row, the lower four symbols are paired with the upper four symbols. Each pair yields a 5-bit unsigned integer sum, and the carry is kept. A parity bit is also formed down each bit column, across the two rows.

The result is a systematic codeword made of the original 64 data bits, 40 sum bits and 32 parity bits. The parity computation is combinational. The data bits and both check fields are captured in output registers when the input strobe is high, so the valid output follows the valid input by one clock. A later decoder can recompute the same fields from a read word. It can then compare them by integer subtraction and XOR to locate and repair upsets that affect several adjacent cells.

Top module: `sym_matrix_enc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid`, `out_data`, `out_hsum` and `out_vpar` are all zero.
- R2: `out_valid` is high in exactly those cycles that follow a rising clock edge at which `in_valid` was high.
- R3: After a clock edge with `in_valid` high, `out_data` equals the `in_data` sampled at that edge, bit for bit.
- R4: Symbol k is `D[4k+3:4k]`. For group g (g = 0..7), let r = g/4 and s = g%4. `out_hsum[5g+4:5g]` is the unsigned sum of symbol 8r+s and symbol 8r+s+4. For example, group 0 is `D[3:0]+D[19:16]` and group 5 is `D[39:36]+D[55:52]`.
- R5: Each 5-bit sum keeps its carry. Two symbols of 15 give `5'b11110`, and no group wraps to 4 bits.
- R6: `out_vpar[i]` equals `D[i] XOR D[i+32]` for i = 0..31.
- R7: After a clock edge with `in_valid` low, `out_data`, `out_hsum` and `out_vpar` keep their previous values, and `in_data` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The data word is present this cycle |
| in_data | input | 64 | Data word to encode |
| out_valid | output | 1 | The codeword outputs hold a new word |
| out_data | output | 64 | Data bits passed through unchanged |
| out_hsum | output | 40 | Eight 5-bit symbol-pair sums |
| out_vpar | output | 32 | Column parity across the two rows |

## Verification
All-zero and all-one words separate a correct sum from a wrapped 4-bit sum, because all-ones must give 30 in every group. Walking single ones show that each data bit reaches exactly one sum group and exactly one parity bit, at the right place, which exposes swapped pairings or rows. Random words with invalid bubbles mixed in check the general case. The bubbles also show that the outputs hold while the strobe is low, even when the data input keeps changing.

// File: rtl/sym_matrix_enc.sv
module sym_matrix_enc #(
  parameter int SYM_W        = 4,
  parameter int SYMS_PER_ROW = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic [2*SYM_W*SYMS_PER_ROW-1:0]     in_data,
  output logic                                out_valid,
  output logic [2*SYM_W*SYMS_PER_ROW-1:0]     out_data,
  output logic [(SYM_W+1)*SYMS_PER_ROW-1:0]   out_hsum,
  output logic [SYM_W*SYMS_PER_ROW-1:0]       out_vpar
);
  localparam int ROW_W  = SYM_W * SYMS_PER_ROW;
  localparam int DATA_W = 2 * ROW_W;
  localparam int HALF   = SYMS_PER_ROW / 2;
  localparam int GRP_W  = SYM_W + 1;
  localparam int NGRP   = SYMS_PER_ROW;

  logic [NGRP*GRP_W-1:0] hsum_c;
  logic [ROW_W-1:0]      vpar_c;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO_BIT = (g / HALF) * ROW_W + (g % HALF) * SYM_W;
    localparam int HI_BIT = LO_BIT + HALF * SYM_W;
    assign hsum_c[g*GRP_W +: GRP_W] =
      GRP_W'(in_data[LO_BIT +: SYM_W]) + GRP_W'(in_data[HI_BIT +: SYM_W]);

    AST_HSUM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_hsum[g*GRP_W +: GRP_W] ==
        GRP_W'(out_data[LO_BIT +: SYM_W]) + GRP_W'(out_data[HI_BIT +: SYM_W])); // R4
  end

  assign vpar_c = in_data[ROW_W-1:0] ^ in_data[DATA_W-1:ROW_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_hsum  <= '0;
      out_vpar  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= in_data;
        out_hsum <= hsum_c;
        out_vpar <= vpar_c;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data == $past(in_data)); // R3
  AST_VPAR_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_vpar == (out_data[ROW_W-1:0] ^ out_data[DATA_W-1:ROW_W])); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_hsum) && $stable(out_vpar))); // R7
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0 && out_hsum == '0 && out_vpar == '0)); // R1
endmodule

// File: tb/sym_matrix_enc_bench.sv
`timescale 1ns/1ps
module sym_matrix_enc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [39:0] out_hsum;
  logic [31:0] out_vpar;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic        exp_valid = 1'b0;
  logic [63:0] exp_data = '0;
  logic [39:0] exp_hsum = '0;
  logic [31:0] exp_vpar = '0;

  always #2 clk = ~clk;

  sym_matrix_enc u_sym_matrix_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_hsum(out_hsum), .out_vpar(out_vpar)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] model_hsum(input logic [63:0] d);
    logic [39:0] h = '0;
    for (int g = 0; g < 8; g++) begin
      int lo = (g / 4) * 32 + (g % 4) * 4;
      int a = int'((d >> lo) & 64'hF);
      int b = int'((d >> (lo + 16)) & 64'hF);
      int sum = a + b;
      h = h | (40'(sum) << (5 * g));
    end
    return h;
  endfunction

  function automatic logic [31:0] model_vpar(input logic [63:0] d);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = d[i] ^ d[i+32];
    return v;
  endfunction

  task automatic compare_all();
    check("R2 out_valid", {63'd0, out_valid}, {63'd0, exp_valid});
    check(exp_valid ? "R3 out_data" : "R7 out_data hold", out_data, exp_data);
    check(exp_valid ? "R4 out_hsum" : "R7 out_hsum hold", {24'd0, out_hsum}, {24'd0, exp_hsum});
    check(exp_valid ? "R6 out_vpar" : "R7 out_vpar hold", {32'd0, out_vpar}, {32'd0, exp_vpar});
  endtask

  task automatic step(input logic v, input logic [63:0] d);
    @(negedge clk);
    compare_all();
    in_valid = v;
    in_data  = d;
    exp_valid = v;
    if (v) begin
      exp_data = d;
      exp_hsum = model_hsum(d);
      exp_vpar = model_vpar(d);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset out_data", out_data, 64'd0);
    check("R1 reset out_hsum", {24'd0, out_hsum}, 64'd0);
    check("R1 reset out_vpar", {32'd0, out_vpar}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {out_valid, out_data[62:0]}, 64'd0);

    step(1'b1, 64'd0);
    step(1'b1, '1);
    @(posedge clk); #1;
    check("R5 carry kept all groups 30", {24'd0, out_hsum}, {24'd0, {8{5'b11110}}});
    step(1'b1, 64'h0000_000F_0000_0001);
    step(1'b0, 64'hDEAD_BEEF_1234_5678);
    step(1'b0, 64'h0123_4567_89AB_CDEF);
    for (int b = 0; b < 64; b++) step(1'b1, 64'd1 << b);
    step(1'b1, 64'hF0F0_F0F0_0F0F_0F0F);
    step(1'b1, 64'hAAAA_AAAA_5555_5555);
    for (int n = 0; n < 200; n++)
      step(($urandom % 4) != 0, {$urandom, $urandom});
    step(1'b0, 64'd0);
    step(1'b0, 64'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule